// File: doc/BRIEF.md
# Host Command Intake Sequencer

This block is the host-facing front end of a disk-controller style peripheral. The host writes an opcode byte into a data port and then the parameter bytes that opcode needs. It paces the host through two status bits. `rqm` says the block is ready for a byte. `dio` says the transfer direction: 0 means host to block, and 1 means the block has left the command phase.

The block looks up how many parameter bytes each opcode carries and counts them in. An opcode it does not recognise is flagged and ends the command phase on its own. After the final byte it enters the execution phase without any further host action. A stub `exec_done` pulse then returns it to command intake.

Three reset sources feed one internal core reset:
- The hardware pin `rst_n`.
- A sticky hold bit, which the pin sets and only the host clears.
- A one-shot pulse reset, which clears itself.

The core reset is also brought out so that drive-status and FIFO logic elsewhere can be cleared along with this block.

Top module: `cmd_intake`

## Requirements
- R1: A data write (`host_wr`) is taken only in a cycle where `rqm`=1 and `dio`=0. Writes at any other time, including during core reset, the processing cycle or execution, change no state.
- R2: After every accepted byte, `rqm` is 0 for exactly the next cycle while the byte is processed.
- R3: The opcode is decoded from bits [4:0] of the first byte, and bits [7:5] are ignored. Parameter counts: 0x03→2, 0x04→1, 0x05→8, 0x06→8, 0x07→1, 0x08→0, 0x0A→1, 0x0F→2, 0x13→3. Any other value is illegal. After each byte, `rqm` returns to 1 while parameter bytes remain.
- R4: After the last byte of a legal command, the block is in execution with `rqm`=0 and `dio`=1. `cmd_opcode` holds the full first byte and `param_cnt` equals the parameter count.
- R5: An illegal opcode sets `invalid_cmd`=1 and moves straight to execution (`rqm`=0, `dio`=1) with no parameter bytes.
- R6: `fifo_en` is 0 throughout the command phase and for an illegal command. It is 1 in the execution phase of a legal command.
- R7: A `pulse_rst` request raises `core_reset` for exactly one cycle, after which it falls by itself.
- R8: `rst_n` low sets `hold_bit`. The bit stays 1 until a `hold_wr` with `hold_val`=0 clears it, and a `hold_wr` with `hold_val`=1 sets it. `core_reset` is 1 while `hold_bit` is 1.
- R9: While `hold_bit` is 1, a pulse reset does not shorten the reset: `core_reset` stays 1 until the hold bit is cleared.
- R10: While `core_reset` is 1, `rqm`=0. When `core_reset` falls, the block is in command phase with `rqm`=1, `dio`=0, `invalid_cmd`=0 and `param_cnt`=0, waiting for an opcode.
- R11: An `exec_done` pulse during execution returns the block to command phase (`rqm`=1, `dio`=0, `invalid_cmd`=0) in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware pin reset, active low, asynchronous |
| host_wr | input | 1 | Host write strobe for the data port |
| host_data | input | 8 | Host write data (opcode or parameter) |
| hold_wr | input | 1 | Host write strobe for the sticky reset bit |
| hold_val | input | 1 | Value written to the sticky reset bit |
| pulse_rst | input | 1 | Request for a self-clearing reset |
| exec_done | input | 1 | Stub: execution finished |
| rqm | output | 1 | Ready for a host byte |
| dio | output | 1 | Direction; 1 when the block is in the execution phase |
| core_reset | output | 1 | Merged software reset to the core |
| hold_bit | output | 1 | Current value of the sticky reset bit |
| fifo_en | output | 1 | Data FIFO enable |
| invalid_cmd | output | 1 | Last opcode was illegal |
| cmd_opcode | output | 8 | Captured opcode byte |
| param_cnt | output | 4 | Parameter bytes received for the current command |

## Verification
A wrong remaining-byte count or a wrong phase register shows at the ports within one or two cycles of the byte that caused it. `rqm` either comes back when it should stay low, or the reverse, and `dio` rises early or late. A mis-decoded opcode is therefore visible no later than the cycle after its own last expected byte. A reset source that fails to merge or clear shows at once as `core_reset` and `rqm` holding the wrong level on the next cycle. The bench sweeps all 256 opcode values and feeds each its full parameter list, so every table entry is compared.

// File: rtl/cmd_intake.sv
module cmd_intake #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [DW-1:0] host_data,
  input  logic          hold_wr,
  input  logic          hold_val,
  input  logic          pulse_rst,
  input  logic          exec_done,
  output logic          rqm,
  output logic          dio,
  output logic          core_reset,
  output logic          hold_bit,
  output logic          fifo_en,
  output logic          invalid_cmd,
  output logic [DW-1:0] cmd_opcode,
  output logic [CW-1:0] param_cnt
);
  localparam int OPW = 5;

  typedef enum logic [1:0] {S_CMD, S_PROC, S_EXEC} st_t;

  st_t           st;
  logic          pulse_q, first_q;
  logic [CW-1:0] left_q;
  logic [CW:0]   dec;
  logic          acc;

  function automatic logic [CW:0] lookup(input logic [OPW-1:0] op);
    case (op)
      5'h03:   return {1'b1, CW'(2)};
      5'h04:   return {1'b1, CW'(1)};
      5'h05:   return {1'b1, CW'(8)};
      5'h06:   return {1'b1, CW'(8)};
      5'h07:   return {1'b1, CW'(1)};
      5'h08:   return {1'b1, CW'(0)};
      5'h0A:   return {1'b1, CW'(1)};
      5'h0F:   return {1'b1, CW'(2)};
      5'h13:   return {1'b1, CW'(3)};
      default: return '0;
    endcase
  endfunction

  assign core_reset = hold_bit | pulse_q;
  assign rqm        = (st == S_CMD)  & ~core_reset;
  assign dio        = (st == S_EXEC) & ~core_reset;
  assign fifo_en    = dio & ~invalid_cmd;
  assign acc        = host_wr & rqm & ~dio;
  assign dec        = lookup(host_data[OPW-1:0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       hold_bit <= 1'b1;
    else if (hold_wr) hold_bit <= hold_val;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_CMD;
      first_q     <= 1'b1;
      left_q      <= '0;
      invalid_cmd <= 1'b0;
      cmd_opcode  <= '0;
      param_cnt   <= '0;
    end else if (core_reset) begin
      st          <= S_CMD;
      first_q     <= 1'b1;
      left_q      <= '0;
      invalid_cmd <= 1'b0;
      param_cnt   <= '0;
    end else begin
      case (st)
        S_CMD: if (acc) begin
          st <= S_PROC;
          if (first_q) begin
            first_q     <= 1'b0;
            cmd_opcode  <= host_data;
            param_cnt   <= '0;
            invalid_cmd <= ~dec[CW];
            left_q      <= dec[CW] ? dec[CW-1:0] : '0;
          end else begin
            left_q    <= left_q - 1'b1;
            param_cnt <= param_cnt + 1'b1;
          end
        end
        S_PROC: begin
          if (invalid_cmd || left_q == '0) begin
            st      <= S_EXEC;
            first_q <= 1'b1;
          end else begin
            st <= S_CMD;
          end
        end
        S_EXEC: if (exec_done) begin
          st          <= S_CMD;
          invalid_cmd <= 1'b0;
        end
        default: st <= S_CMD;
      endcase
    end
  end
endmodule

module cmd_intake_chk (
  input logic clk,
  input logic rst_n,
  input logic host_wr,
  input logic hold_wr,
  input logic hold_val,
  input logic pulse_rst,
  input logic exec_done,
  input logic rqm,
  input logic dio,
  input logic core_reset,
  input logic hold_bit,
  input logic fifo_en
);
  p_rqm_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && rqm && !dio) |=> !rqm);

  p_exec_no_rqm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dio |-> !rqm);

  p_fifo_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rqm |-> !fifo_en);

  p_pulse_self_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_bit && !pulse_rst && !(hold_wr && hold_val)) |=> !core_reset);

  p_hold_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_bit && !hold_wr) |=> (hold_bit && core_reset));

  p_hold_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_bit && pulse_rst && !hold_wr) |=> core_reset);

  p_rst_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_reset) |-> (rqm && !dio));

  p_done_back_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dio && exec_done && !hold_bit && !pulse_rst && !hold_wr) |=> (rqm && !dio));
endmodule

bind cmd_intake cmd_intake_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .hold_wr(hold_wr),
  .hold_val(hold_val), .pulse_rst(pulse_rst), .exec_done(exec_done),
  .rqm(rqm), .dio(dio), .core_reset(core_reset), .hold_bit(hold_bit),
  .fifo_en(fifo_en)
);

// File: tb/cmd_intake_bench.sv
`timescale 1ns/1ps
module cmd_intake_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0, hold_wr = 1'b0, hold_val = 1'b0;
  logic pulse_rst = 1'b0, exec_done = 1'b0;
  logic [7:0] host_data = '0;
  logic rqm, dio, core_reset, hold_bit, fifo_en, invalid_cmd;
  logic [7:0] cmd_opcode;
  logic [3:0] param_cnt;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  cmd_intake u_cmd_intake (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_data(host_data),
    .hold_wr(hold_wr), .hold_val(hold_val), .pulse_rst(pulse_rst),
    .exec_done(exec_done), .rqm(rqm), .dio(dio), .core_reset(core_reset),
    .hold_bit(hold_bit), .fifo_en(fifo_en), .invalid_cmd(invalid_cmd),
    .cmd_opcode(cmd_opcode), .param_cnt(param_cnt)
  );

  function automatic int exp_count(input logic [4:0] op);
    case (op)
      5'h03, 5'h0F: return 2;
      5'h04, 5'h07, 5'h0A: return 1;
      5'h05, 5'h06: return 8;
      5'h08: return 0;
      5'h13: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    host_wr = 1'b1; host_data = b;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic done_pulse();
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hold_bit, 1, "R8 hold set by pin");
    chk(core_reset, 1, "R8 reset while hold");
    chk(rqm, 0, "R10 rqm low in reset");
    wr_byte(8'h08);
    chk(dio, 0, "R1 write in reset ignored");
    hold_wr = 1'b1; hold_val = 1'b0;
    @(negedge clk);
    hold_wr = 1'b0;
    chk(core_reset, 0, "R8 hold cleared");
    chk(rqm, 1, "R10 rqm after reset");
    chk(dio, 0, "R1 no command started in reset");
    chk(param_cnt, 0, "R10 count cleared");

    for (int op = 0; op < 256; op++) begin
      int e;
      e = exp_count(op[4:0]);
      wr_byte(op[7:0]);
      chk(rqm, 0, "R2 rqm low after opcode");
      @(negedge clk);
      if (e < 0) begin
        chk(invalid_cmd, 1, "R5 invalid flag");
        chk(dio, 1, "R5 exec on illegal");
        chk(rqm, 0, "R5 rqm low");
        chk(fifo_en, 0, "R6 fifo off illegal");
      end else begin
        for (int k = 0; k < e; k++) begin
          chk(rqm, 1, "R3 param request");
          chk(fifo_en, 0, "R6 fifo off in command");
          wr_byte(8'(k + 8'hA0));
          chk(rqm, 0, "R2 rqm low after param");
          @(negedge clk);
        end
        chk(dio, 1, "R4 exec phase");
        chk(rqm, 0, "R4 rqm low in exec");
        chk(param_cnt, e, "R4 param count");
        chk(cmd_opcode, op, "R4 opcode held");
        chk(invalid_cmd, 0, "R4 legal flag");
        chk(fifo_en, 1, "R6 fifo on in exec");
        wr_byte(8'h55);
        chk(param_cnt, e, "R1 exec write ignored");
        chk(dio, 1, "R1 still exec");
      end
      done_pulse();
      chk(rqm, 1, "R11 back to command");
      chk(dio, 0, "R11 dio low");
      chk(invalid_cmd, 0, "R11 flag cleared");
    end

    // write during processing cycle is ignored
    host_wr = 1'b1; host_data = 8'h03;
    @(negedge clk);
    @(negedge clk);
    host_wr = 1'b0;
    chk(rqm, 1, "R1 second write ignored");
    chk(param_cnt, 0, "R1 no param counted");
    wr_byte(8'h11);
    @(negedge clk);
    chk(param_cnt, 1, "R3 one param in");
    chk(rqm, 1, "R3 one more requested");

    // pulse reset mid-command
    pulse_rst = 1'b1;
    @(negedge clk);
    pulse_rst = 1'b0;
    chk(core_reset, 1, "R7 pulse reset high");
    chk(rqm, 0, "R10 rqm low in pulse");
    @(negedge clk);
    chk(core_reset, 0, "R7 pulse self-clears");
    chk(rqm, 1, "R10 rqm after pulse");
    chk(param_cnt, 0, "R10 count cleared");
    wr_byte(8'h08);
    @(negedge clk);
    chk(dio, 1, "R10 fresh opcode taken");
    done_pulse();

    // hold precedence
    hold_wr = 1'b1; hold_val = 1'b1;
    @(negedge clk);
    hold_wr = 1'b0;
    chk(hold_bit, 1, "R8 hold set by write");
    pulse_rst = 1'b1;
    @(negedge clk);
    pulse_rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(core_reset, 1, "R9 hold outlasts pulse");
      chk(rqm, 0, "R9 rqm held low");
    end
    hold_wr = 1'b1; hold_val = 1'b0;
    @(negedge clk);
    hold_wr = 1'b0;
    chk(core_reset, 0, "R9 released by hold clear");
    chk(rqm, 1, "R10 ready after hold");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule